// File: doc/BRIEF.md
# Input-Capture Timer with Edge-Controlled Clear

This block is a free-running up-counter that timestamps transitions on an external capture pin. The pin is brought into the main clock domain by a two-flop synchroniser. It then either passes straight through or passes through a sampling noise filter. Each accepted transition does three things: it copies the counter into a rising-edge or falling-edge capture register, it can reset the counter to zero, and it can raise a one-cycle interrupt strobe.

The counter advances on a prescaled tick. The tick is taken from the system clock divided by 64, 32 or 2, or from a slow external clock divided by 2. The controls are independent of each other:

- the edge that raises the interrupt;
- the edges that clear the counter;
- the tick source;
- the filter enable.

The controls are plain input ports, so a surrounding register block can drive them directly.

The filter is a two-state machine. `FLT_STEADY` is entered at reset. On a tick whose sample differs from the accepted level, the machine moves `FLT_STEADY -> FLT_PENDING` (disagree). On a tick whose sample matches the accepted level again, it moves `FLT_PENDING -> FLT_STEADY` (abandon). When the run of disagreeing samples reaches its length, it moves `FLT_PENDING -> FLT_STEADY` (accept). When the filter is disabled, the move `FLT_STEADY -> FLT_STEADY` (accept) happens on the first disagreeing sample.

Top module: `capture_timer`

## Requirements
- R1: After reset, `count`, `cap_rise` and `cap_fall` are zero and `cap_irq` and `ovf` are low. The accepted capture level is low.
- R2: `clk_sel` picks the tick source:
  - 00: one tick every 64 `clk` cycles.
  - 01: one tick every 32 `clk` cycles.
  - 10: one tick every 2 `clk` cycles.
  - 11: one tick every second rising edge of `sub_clk_in`, after that input has passed a two-flop synchroniser.
- R3: The counter changes only on a tick, by +1, and wraps from 0xFF to 0x00. A clear takes precedence over the increment.
- R4: `cap_irq` is a single-cycle pulse for an accepted edge. With `irq_edge_sel`=0 the edge is rising; with `irq_edge_sel`=1 it is falling.
- R5: `clr_mode` sets which accepted edges reset the counter to zero on that same tick: 00 none, 01 falling, 10 rising, 11 both.
- R6: An accepted rising edge loads `cap_rise`, and an accepted falling edge loads `cap_fall`, with the counter value from before that tick's clear or increment.
- R7: With `filt_en`=1, a new level is accepted only on the third consecutive tick that samples it. Any shorter excursion is discarded and produces no capture, clear or interrupt.
- R8: `ovf` pulses high for one cycle when the counter wraps from 0xFF to 0x00. There is no pulse when a clear lands on 0xFF.
- R9: With `filt_en`=0, the synchronised pin level is accepted on the first tick that samples it. The pin reaches the sampler two `clk` cycles after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_clk_in | input | 1 | Slow clock used as the fourth tick source |
| cap_pin | input | 1 | Capture input pin |
| irq_edge_sel | input | 1 | Interrupt edge: 0 rising, 1 falling |
| clr_mode | input | 2 | Clear edges: 00 none, 01 fall, 10 rise, 11 both |
| clk_sel | input | 2 | Tick source: 00 /64, 01 /32, 10 /2, 11 slow clock /2 |
| filt_en | input | 1 | Enables the three-sample noise filter |
| count | output | CNT_W | Counter value |
| cap_rise | output | CNT_W | Counter latched on accepted rising edge |
| cap_fall | output | CNT_W | Counter latched on accepted falling edge |
| cap_irq | output | 1 | One-cycle capture interrupt strobe |
| ovf | output | 1 | One-cycle wrap strobe |

## Verification
The single-cycle pulse properties assume that two ticks never fall on adjacent `clk` cycles. This holds for the divided sources. For the slow source, `sub_clk_in` must hold each level for at least two `clk` cycles. The stimulus toggles `sub_clk_in` every three cycles. It holds `cap_pin` for random spans of 1 to 12 cycles and uses directed pulses three cycles wide to probe the filter. Control inputs change only between stimulus spans, and the assertions tolerate changes at any cycle.

// File: rtl/capture_timer_pkg.sv
package capture_timer_pkg;

    typedef enum logic [1:0] {
        CKS_DIV_SLOW = 2'b00,
        CKS_DIV_MID  = 2'b01,
        CKS_DIV_FAST = 2'b10,
        CKS_SUB      = 2'b11
    } tick_src_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_FALL = 2'b01,
        CLR_RISE = 2'b10,
        CLR_BOTH = 2'b11
    } clr_mode_e;

    typedef enum logic {
        FLT_STEADY  = 1'b0,
        FLT_PENDING = 1'b1
    } flt_state_e;

endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler
    import capture_timer_pkg::*;
#(
    parameter int DIV_SLOW = 64,
    parameter int DIV_MID  = 32,
    parameter int DIV_FAST = 2,
    parameter int SUB_DIV  = 2,
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_clk_in,
    input  logic [1:0] clk_sel,
    output logic       tick
);
    localparam int PRE_W = $clog2(DIV_SLOW);
    localparam int SUB_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
    localparam logic [PRE_W-1:0] MASK_SLOW = PRE_W'(DIV_SLOW - 1);
    localparam logic [PRE_W-1:0] MASK_MID  = PRE_W'(DIV_MID - 1);
    localparam logic [PRE_W-1:0] MASK_FAST = PRE_W'(DIV_FAST - 1);
    localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(SUB_DIV - 1);

    logic [PRE_W-1:0]  pre_cnt;
    logic [SYNC_LEN:0] sub_sh;
    logic [SUB_W-1:0]  sub_cnt;
    logic              sub_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            sub_sh  <= '0;
            sub_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
            sub_sh  <= {sub_sh[SYNC_LEN-1:0], sub_clk_in};
            if (sub_rise) begin
                sub_cnt <= (sub_cnt == SUB_LAST) ? '0 : sub_cnt + 1'b1;
            end
        end
    end

    assign sub_rise = sub_sh[SYNC_LEN-1] & ~sub_sh[SYNC_LEN];

    always_comb begin
        unique case (tick_src_e'(clk_sel))
            CKS_DIV_SLOW: tick = ((pre_cnt & MASK_SLOW) == MASK_SLOW);
            CKS_DIV_MID:  tick = ((pre_cnt & MASK_MID) == MASK_MID);
            CKS_DIV_FAST: tick = ((pre_cnt & MASK_FAST) == MASK_FAST);
            CKS_SUB:      tick = sub_rise && (sub_cnt == SUB_LAST);
            default:      tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ct_edge_filter.sv
module ct_edge_filter
    import capture_timer_pkg::*;
#(
    parameter int FILT_LEN = 3,
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic filt_en,
    input  logic cap_pin,
    output logic edge_rise,
    output logic edge_fall
);
    localparam int RUN_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) + 1 : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

    logic [SYNC_LEN-1:0] pin_sh;
    logic                sample;
    flt_state_e          state, state_nx;
    logic [RUN_W-1:0]    run_cnt, run_nx;
    logic                lvl, lvl_nx;
    logic                accept;

    assign sample = pin_sh[SYNC_LEN-1];

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_sh  <= '0;
            state   <= FLT_STEADY;
            run_cnt <= '0;
            lvl     <= 1'b0;
        end else begin
            pin_sh  <= {pin_sh[SYNC_LEN-2:0], cap_pin};
            state   <= state_nx;
            run_cnt <= run_nx;
            lvl     <= lvl_nx;
        end
    end

    // next-state process
    always_comb begin
        state_nx = state;
        run_nx   = run_cnt;
        accept   = 1'b0;
        if (tick) begin
            unique case (state)
                FLT_STEADY: begin
                    if (sample != lvl) begin
                        if (!filt_en || FILT_LEN <= 1) begin
                            accept = 1'b1;
                        end else begin
                            state_nx = FLT_PENDING;
                            run_nx   = RUN_W'(1);
                        end
                    end
                end
                FLT_PENDING: begin
                    if (sample == lvl) begin
                        state_nx = FLT_STEADY;
                        run_nx   = '0;
                    end else if (!filt_en || run_cnt >= RUN_LAST) begin
                        accept   = 1'b1;
                        state_nx = FLT_STEADY;
                        run_nx   = '0;
                    end else begin
                        run_nx = run_cnt + 1'b1;
                    end
                end
                default: state_nx = FLT_STEADY;
            endcase
        end
        lvl_nx = accept ? sample : lvl;
    end

    // output process
    always_comb begin
        edge_rise = accept & sample;
        edge_fall = accept & ~sample;
    end

endmodule

// File: rtl/ct_counter.sv
module ct_counter
    import capture_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             edge_rise,
    input  logic             edge_fall,
    input  logic [1:0]       clr_mode,
    input  logic             irq_edge_sel,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_rise,
    output logic [CNT_W-1:0] cap_fall,
    output logic             cap_irq,
    output logic             ovf
);
    logic clr_hit;
    logic at_top;

    always_comb begin
        unique case (clr_mode_e'(clr_mode))
            CLR_NONE: clr_hit = 1'b0;
            CLR_FALL: clr_hit = edge_fall;
            CLR_RISE: clr_hit = edge_rise;
            CLR_BOTH: clr_hit = edge_rise | edge_fall;
            default:  clr_hit = 1'b0;
        endcase
    end

    assign at_top = (count == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            cap_rise <= '0;
            cap_fall <= '0;
            cap_irq  <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            cap_irq <= irq_edge_sel ? edge_fall : edge_rise;
            ovf     <= tick & at_top & ~clr_hit;
            if (edge_rise) cap_rise <= count;
            if (edge_fall) cap_fall <= count;
            if (tick) begin
                count <= clr_hit ? '0 : count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import capture_timer_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int DIV_SLOW = 64,
    parameter int DIV_MID  = 32,
    parameter int DIV_FAST = 2,
    parameter int SUB_DIV  = 2,
    parameter int FILT_LEN = 3,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_clk_in,
    input  logic             cap_pin,
    input  logic             irq_edge_sel,
    input  logic [1:0]       clr_mode,
    input  logic [1:0]       clk_sel,
    input  logic             filt_en,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_rise,
    output logic [CNT_W-1:0] cap_fall,
    output logic             cap_irq,
    output logic             ovf
);
    logic tick;
    logic edge_rise;
    logic edge_fall;

    ct_prescaler #(
        .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST),
        .SUB_DIV(SUB_DIV), .SYNC_LEN(SYNC_LEN)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .sub_clk_in(sub_clk_in),
        .clk_sel(clk_sel), .tick(tick)
    );

    ct_edge_filter #(.FILT_LEN(FILT_LEN), .SYNC_LEN(SYNC_LEN)) u_flt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .filt_en(filt_en),
        .cap_pin(cap_pin), .edge_rise(edge_rise), .edge_fall(edge_fall)
    );

    ct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .edge_rise(edge_rise), .edge_fall(edge_fall),
        .clr_mode(clr_mode), .irq_edge_sel(irq_edge_sel),
        .count(count), .cap_rise(cap_rise), .cap_fall(cap_fall),
        .cap_irq(cap_irq), .ovf(ovf)
    );

endmodule

// File: rtl/capture_timer_chk.sv
module capture_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             edge_rise,
    input logic             edge_fall,
    input logic [1:0]       clr_mode,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] cap_rise,
    input logic [CNT_W-1:0] cap_fall,
    input logic             cap_irq,
    input logic             ovf
);
    logic clr_now;
    assign clr_now = (edge_rise && clr_mode[1]) || (edge_fall && clr_mode[0]);

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_now) |=> count == $past(count) + 1'b1); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |=> !cap_irq); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> count == '0); // R5
    AST_CAP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_rise |=> cap_rise == $past(count)); // R6
    AST_CAP_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        edge_fall |=> cap_fall == $past(count)); // R6
    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_rise || edge_fall) |-> tick); // R7
    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf); // R8
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> count == '0); // R8

endmodule

bind capture_timer capture_timer_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_capture_timer.sv
module test_capture_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_clk_in = 1'b0;
    logic       cap_pin = 1'b0;
    logic       irq_edge_sel = 1'b0;
    logic [1:0] clr_mode = 2'b00;
    logic [1:0] clk_sel = 2'b00;
    logic       filt_en = 1'b0;
    logic [7:0] count, cap_rise, cap_fall;
    logic       cap_irq, ovf;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    capture_timer i_capture_timer (
        .clk(clk), .rst_n(rst_n), .sub_clk_in(sub_clk_in), .cap_pin(cap_pin),
        .irq_edge_sel(irq_edge_sel), .clr_mode(clr_mode), .clk_sel(clk_sel),
        .filt_en(filt_en), .count(count), .cap_rise(cap_rise), .cap_fall(cap_fall),
        .cap_irq(cap_irq), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    int       m_pre, m_subc, m_run;
    bit [2:0] m_sub;
    bit [1:0] m_pin;
    bit       m_lvl, m_irq, m_ovf;
    bit [7:0] m_cnt, m_rise, m_fall;

    function automatic bit tick_fn(bit [1:0] sel, int pre, bit [2:0] sh, int subc);
        case (sel)
            2'b00:   return (pre % 64) == 63;
            2'b01:   return (pre % 32) == 31;
            2'b10:   return (pre % 2) == 1;
            default: return sh[1] && !sh[2] && (subc == 1);
        endcase
    endfunction

    function automatic bit clears(bit [1:0] mode, bit er, bit ef);
        return (mode[1] && er) || (mode[0] && ef);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_subc = 0; m_run = 0; m_sub = 0; m_pin = 0;
            m_lvl = 0; m_irq = 0; m_ovf = 0; m_cnt = 0; m_rise = 0; m_fall = 0;
        end else begin
            bit tk, samp, er, ef, clr;
            tk = tick_fn(clk_sel, m_pre, m_sub, m_subc);
            samp = m_pin[1];
            er = 0; ef = 0;
            if (tk) begin
                if (samp != m_lvl) begin
                    m_run = m_run + 1;
                    if (!filt_en || m_run >= 3) begin
                        er = samp; ef = !samp; m_lvl = samp; m_run = 0;
                    end
                end else m_run = 0;
            end
            clr = clears(clr_mode, er, ef);
            m_irq = irq_edge_sel ? ef : er;
            m_ovf = tk && (m_cnt == 8'hFF) && !clr;
            if (er) m_rise = m_cnt;
            if (ef) m_fall = m_cnt;
            if (tk) m_cnt = clr ? 8'h00 : m_cnt + 8'h01;
            m_pre = (m_pre + 1) % 64;
            if (m_sub[1] && !m_sub[2]) m_subc = m_subc ^ 1;
            m_sub = {m_sub[1:0], sub_clk_in};
            m_pin = {m_pin[0], cap_pin};
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check(cur_req, "count", count, m_cnt);
            check("R6", "cap_rise", cap_rise, m_rise);
            check("R6", "cap_fall", cap_fall, m_fall);
            check("R4", "cap_irq", cap_irq, m_irq);
            check("R8", "ovf", ovf, m_ovf);
        end
    end

    // slow clock source: toggles every three cycles
    int sub_div = 0;
    always @(negedge clk) begin
        sub_div++;
        if (sub_div == 3) begin sub_div = 0; sub_clk_in <= ~sub_clk_in; end
    end

    // watchdog
    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic toggle_run(int n, int period);
        for (int i = 0; i < n; i++) begin
            cap_pin = ~cap_pin;
            wait_cyc(period);
        end
    endtask

    initial begin
        int seen_irq;
        logic [7:0] c0, r0;
        void'($urandom(32'h5EED_1234));
        wait_cyc(4);
        // R1: reset state
        check("R1", "count reset", count, 0);
        check("R1", "cap_rise reset", cap_rise, 0);
        check("R1", "cap_fall reset", cap_fall, 0);
        check("R1", "irq/ovf reset", {cap_irq, ovf}, 0);
        rst_n = 1'b1;

        // R2: each tick source
        cur_req = "R2";
        clk_sel = 2'b00; wait_cyc(300);
        clk_sel = 2'b01; wait_cyc(200);
        clk_sel = 2'b11; wait_cyc(300);
        clk_sel = 2'b10; wait_cyc(3);
        c0 = count; wait_cyc(40);
        check("R2", "div2 advance over 40 cycles", count, 8'(c0 + 8'd20));
        clk_sel = 2'b00;
        c0 = count; wait_cyc(128);
        check("R2", "div64 advance over 128 cycles", count, 8'(c0 + 8'd2));

        // R9: unfiltered path with rising interrupt then falling interrupt
        cur_req = "R9";
        clk_sel = 2'b10; filt_en = 0; clr_mode = 2'b00;
        toggle_run(12, 7);
        irq_edge_sel = 1; toggle_run(12, 9);

        // R5: each clear mode
        cur_req = "R5";
        for (int m = 0; m < 4; m++) begin
            clr_mode = 2'(m);
            toggle_run(8, 23);
        end
        clr_mode = 2'b11; clk_sel = 2'b01; toggle_run(6, 70);

        // R7: short pulses rejected by the filter
        cur_req = "R7";
        clk_sel = 2'b10; filt_en = 1; clr_mode = 2'b11; irq_edge_sel = 0;
        if (cap_pin) begin cap_pin = 0; wait_cyc(20); end
        r0 = cap_rise; seen_irq = 0;
        for (int p = 0; p < 10; p++) begin
            cap_pin = 1;
            for (int i = 0; i < 3; i++) begin @(negedge clk); seen_irq += cap_irq; end
            cap_pin = 0;
            for (int i = 0; i < 5; i++) begin @(negedge clk); seen_irq += cap_irq; end
        end
        wait_cyc(10);
        check("R7", "irqs from short pulses", seen_irq, 0);
        check("R7", "cap_rise after short pulses", cap_rise, r0);
        toggle_run(10, 9);

        // R3: constrained random mix
        cur_req = "R3";
        for (int blk = 0; blk < 20; blk++) begin
            clk_sel = 2'($urandom_range(3));
            clr_mode = 2'($urandom_range(3));
            irq_edge_sel = 1'($urandom_range(1));
            filt_en = 1'($urandom_range(1));
            if (clk_sel == 2'b10 && clr_mode == 2'b00) clr_mode = 2'b00;
            for (int j = 0; j < 60; j++) begin
                cap_pin = ~cap_pin;
                wait_cyc($urandom_range(12, 1));
            end
        end
        // R8: force a wrap with no clears
        cur_req = "R8";
        clk_sel = 2'b10; clr_mode = 2'b00; wait_cyc(600);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule